// File: doc/BRIEF.md
# SPI Master Receive Channel

This block is one clocked-serial master channel that only receives. It drives a serial clock and samples the serial data input. Each finished word goes into an 8-bit receive buffer, which the host reads. The host sets these fields:

- which of two prescaler clock enables runs the channel;
- a divisor for the serial clock rate;
- bit order;
- 7-bit or 8-bit frames;
- clock polarity;
- which event raises the interrupt.

The channel does nothing until a channel-start strobe enables it. After that, each frame begins when the host writes the all-ones dummy word to the data register. The received word is read from the same register. The channel never drives a data output.

A typical use is to enable the channel once, then for each word:

1. Write 8'hFF.
2. Wait for the interrupt, or for the busy flag to drop.
3. Read the word.

If a new word completes before the previous one was read, the new word overwrites the buffer and an overrun flag is raised.

Top module: `spi_rx_master`

## Requirements
- R1: Until `chan_start` has been pulsed once after reset, a data write starts no frame and `busy` stays 0.
- R2: The operating tick is `ck_en0` when `cfg_clk_sel`=0 and `ck_en1` when `cfg_clk_sel`=1. Ticks of the enable that is not selected have no effect on `sck` or frame progress.
- R3: While busy, `sck` changes level once every (`cfg_div`+1) operating ticks. A frame of N bits therefore lasts 2·N·(`cfg_div`+1) ticks, and `sck` does not change between ticks.
- R4: The idle level of `sck` is 1 when `cfg_cpol`=0 and 0 when `cfg_cpol`=1. Outside a frame, `sck` sits at that idle level.
- R5: Each bit is sampled from `sdi` at the clock edge that leaves the idle level. With `cfg_lsb_first`=0 the first bit received is the most significant; with 1 it is bit 0.
- R6: `cfg_len8`=1 gives 8-bit frames. `cfg_len8`=0 gives 7-bit frames, which are returned in bits 6..0 with bit 7 read as 0.
- R7: Only a write of 8'hFF while idle and enabled starts a frame. `busy` rises in the cycle after that write and falls when `sck` returns to idle after the last bit. Writes of any value while busy, and writes of other values, are ignored.
- R8: At the end of each frame the word is stored in `rd_data` and `rx_full` goes to 1. A `data_rd` pulse clears `rx_full` and `overrun`.
- R9: If a frame ends while `rx_full`=1 and no `data_rd` pulse arrives in that cycle, `overrun` goes to 1 and `rd_data` takes the new word.
- R10: `irq` is a one-cycle pulse. With `cfg_irq_sel`=0 it fires in the cycle `busy` falls (transfer complete). With `cfg_irq_sel`=1 it fires in the cycle `busy` rises (buffer taken).
- R11: After synchronous reset, the following all read 0: `busy`, `rx_full`, `overrun`, `irq` and `rd_data`. `sck` is at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ck_en0 | input | 1 | First prescaler clock enable |
| ck_en1 | input | 1 | Second prescaler clock enable |
| cfg_clk_sel | input | 1 | Operating clock select (0: ck_en0, 1: ck_en1) |
| cfg_div | input | DIV_W | Serial clock divisor field |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_len8 | input | 1 | 0: 7-bit frame, 1: 8-bit frame |
| cfg_cpol | input | 1 | Clock polarity; idle level is its inverse |
| cfg_irq_sel | input | 1 | 0: transfer-complete interrupt, 1: buffer-empty interrupt |
| chan_start | input | 1 | Channel-start strobe |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Written value (8'hFF triggers a frame) |
| data_rd | input | 1 | Data register read strobe |
| sdi | input | 1 | Serial data input |
| sck | output | 1 | Serial clock |
| busy | output | 1 | Frame in progress |
| rd_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Unread word in buffer |
| overrun | output | 1 | A word was overwritten before being read |
| irq | output | 1 | Interrupt pulse |

## Verification
A wrong tick count or phase state shows on `sck` at the next operating tick. It also shifts the moment `busy` falls by one half-period or more. A wrong bit order, wrong sample edge or wrong frame length appears in `rd_data` at the end of that same frame. A wrong buffer or overrun flag is visible on `rx_full`, `overrun` or `irq` in the cycle after the frame ends. The reference model is compared on every clock, so each of these faults is reported within one cycle of the first port that differs.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam logic [DATA_W-1:0] DUMMY_WORD = '1;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } sck_phase_e;

    typedef struct packed {
        logic lsb_first;
        logic len8;
    } frame_fmt_t;

    function automatic logic [CNT_W-1:0] frame_bits(input logic len8);
        return len8 ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
    endfunction

    function automatic logic idle_level(input logic cpol);
        return ~cpol;
    endfunction

endpackage

// File: rtl/spi_rx_baud.sv
module spi_rx_baud #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ck_en0,
    input  logic             ck_en1,
    input  logic             sel,
    input  logic [DIV_W-1:0] div,
    input  logic             active,
    output logic             tick,
    output logic             half
);

    logic [DIV_W-1:0] cnt;

    assign tick = sel ? ck_en1 : ck_en0;
    assign half = active && tick && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == div) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
    import spi_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic              sdi,
    input  frame_fmt_t        fmt,
    output logic [DATA_W-1:0] data,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] nxt;

    always_comb begin
        if (fmt.lsb_first) begin
            nxt = data >> 1;
            if (fmt.len8) nxt[DATA_W-1] = sdi;
            else          nxt[DATA_W-2] = sdi;
        end else begin
            nxt = {data[DATA_W-2:0], sdi};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            data  <= '0;
            count <= '0;
        end else if (en) begin
            data  <= nxt;
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/spi_rx_master.sv
module spi_rx_master
    import spi_rx_pkg::*;
#(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ck_en0,
    input  logic             ck_en1,
    input  logic             cfg_clk_sel,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_lsb_first,
    input  logic             cfg_len8,
    input  logic             cfg_cpol,
    input  logic             cfg_irq_sel,
    input  logic             chan_start,
    input  logic             data_wr,
    input  logic [7:0]       data_wdata,
    input  logic             data_rd,
    input  logic             sdi,
    output logic             sck,
    output logic             busy,
    output logic [7:0]       rd_data,
    output logic             rx_full,
    output logic             overrun,
    output logic             irq
);

    logic              run;
    sck_phase_e        phase;
    logic              mck_tick;
    logic              half;
    logic              accept;
    logic              sample;
    logic              trail;
    logic              done;
    logic [DATA_W-1:0] shift_data;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_buf;
    frame_fmt_t        fmt;

    assign fmt.lsb_first = cfg_lsb_first;
    assign fmt.len8      = cfg_len8;

    spi_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst    (rst),
        .ck_en0 (ck_en0),
        .ck_en1 (ck_en1),
        .sel    (cfg_clk_sel),
        .div    (cfg_div),
        .active (busy),
        .tick   (mck_tick),
        .half   (half)
    );

    spi_rx_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .en    (sample),
        .sdi   (sdi),
        .fmt   (fmt),
        .data  (shift_data),
        .count (bit_cnt)
    );

    assign accept = data_wr && (data_wdata == DUMMY_WORD) && run && !busy;
    assign sample = half && (phase == PH_IDLE);
    assign trail  = half && (phase == PH_ACTIVE);
    assign done   = trail && (bit_cnt == frame_bits(cfg_len8));

    always_ff @(posedge clk) begin
        if (rst) begin
            run     <= 1'b0;
            busy    <= 1'b0;
            phase   <= PH_IDLE;
            rx_buf  <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (chan_start) run <= 1'b1;

            if (accept)    busy <= 1'b1;
            else if (done) busy <= 1'b0;

            if (sample)     phase <= PH_ACTIVE;
            else if (trail) phase <= PH_IDLE;

            if (data_rd) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
            if (done) begin
                rx_buf  <= shift_data;
                rx_full <= 1'b1;
                if (rx_full && !data_rd) overrun <= 1'b1;
            end

            irq <= (done && !cfg_irq_sel) || (accept && cfg_irq_sel);
        end
    end

    assign sck     = (phase == PH_ACTIVE) ? ~idle_level(cfg_cpol) : idle_level(cfg_cpol);
    assign rd_data = rx_buf;

endmodule

// File: rtl/spi_rx_master_chk.sv
module spi_rx_master_chk (
    input logic clk,
    input logic rst,
    input logic run,
    input logic busy,
    input logic done,
    input logic mck_tick,
    input logic sck,
    input logic cfg_cpol,
    input logic cfg_len8,
    input logic cfg_irq_sel,
    input logic data_wr,
    input logic data_rd,
    input logic rx_full,
    input logic overrun,
    input logic irq,
    input logic rd_msb
);

    p_no_start_r1: assert property (@(posedge clk) disable iff (rst)
        !run |-> !busy);

    p_sck_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !mck_tick) |=> $stable(sck));

    p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == !cfg_cpol));

    p_bit7_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !cfg_len8) |=> !rd_msb);

    p_busy_from_write_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(data_wr));

    p_full_on_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> rx_full);

    p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
        (done && rx_full && !data_rd) |=> overrun);

    p_irq_done_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && !cfg_irq_sel) |-> $fell(busy));

    p_irq_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (irq && cfg_irq_sel) |-> $rose(busy));

endmodule

bind spi_rx_master spi_rx_master_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .busy        (busy),
    .done        (done),
    .mck_tick    (mck_tick),
    .sck         (sck),
    .cfg_cpol    (cfg_cpol),
    .cfg_len8    (cfg_len8),
    .cfg_irq_sel (cfg_irq_sel),
    .data_wr     (data_wr),
    .data_rd     (data_rd),
    .rx_full     (rx_full),
    .overrun     (overrun),
    .irq         (irq),
    .rd_msb      (rd_data[7])
);

// File: tb/sim_spi_rx_master.sv
`timescale 1ns/1ps
module sim_spi_rx_master;

    localparam int DIV_W = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ck_en0 = 1'b0, ck_en1 = 1'b0;
    logic cfg_clk_sel = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic cfg_lsb_first = 1'b0, cfg_len8 = 1'b1, cfg_cpol = 1'b0, cfg_irq_sel = 1'b0;
    logic chan_start = 1'b0, data_wr = 1'b0, data_rd = 1'b0, sdi = 1'b0;
    logic [7:0] data_wdata = '0;
    logic sck, busy, rx_full, overrun, irq;
    logic [7:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit en1_on = 1'b1;
    int en_cnt = 0;

    always #4 clk = ~clk;

    spi_rx_master #(.DIV_W(DIV_W)) u0 (
        .clk(clk), .rst(rst), .ck_en0(ck_en0), .ck_en1(ck_en1),
        .cfg_clk_sel(cfg_clk_sel), .cfg_div(cfg_div), .cfg_lsb_first(cfg_lsb_first),
        .cfg_len8(cfg_len8), .cfg_cpol(cfg_cpol), .cfg_irq_sel(cfg_irq_sel),
        .chan_start(chan_start), .data_wr(data_wr), .data_wdata(data_wdata),
        .data_rd(data_rd), .sdi(sdi), .sck(sck), .busy(busy), .rd_data(rd_data),
        .rx_full(rx_full), .overrun(overrun), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    bit m_run, m_busy, m_active, m_full, m_ovr, m_irq;
    int m_k;
    bit m_bits[$];
    logic [7:0] m_buf;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_busy = 0; m_active = 0; m_full = 0; m_ovr = 0; m_irq = 0;
            m_k = 0; m_bits.delete(); m_buf = 8'h00;
        end else begin
            bit tick, fin, acc;
            int nb, h;
            logic [7:0] w;
            tick = cfg_clk_sel ? ck_en1 : ck_en0;
            nb = cfg_len8 ? 8 : 7;
            fin = 0;
            acc = data_wr && (data_wdata == 8'hFF) && m_run && !m_busy;
            if (m_busy && tick) begin
                m_k++;
                if (m_k % (int'(cfg_div) + 1) == 0) begin
                    h = m_k / (int'(cfg_div) + 1);
                    if (h % 2 == 1) begin
                        m_bits.push_back(sdi);
                        m_active = 1;
                    end else begin
                        m_active = 0;
                        if (h == 2 * nb) fin = 1;
                    end
                end
            end
            if (data_rd) begin m_full = 0; m_ovr = 0; end
            if (fin) begin
                w = 8'h00;
                for (int i = 0; i < nb; i++) begin
                    if (cfg_lsb_first) w[i] = m_bits[i];
                    else               w[nb-1-i] = m_bits[i];
                end
                m_buf = w;
                if (m_full) m_ovr = 1;
                m_full = 1;
                m_busy = 0;
            end
            m_irq = (fin && !cfg_irq_sel) || (acc && cfg_irq_sel);
            if (acc) begin
                m_busy = 1; m_k = 0; m_bits.delete();
            end
            if (chan_start) m_run = 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R3 sck", sck, m_active ? cfg_cpol : !cfg_cpol);
            chk("R7 busy", busy, m_busy);
            chk("R5 rd_data", rd_data, m_buf);
            chk("R8 rx_full", rx_full, m_full);
            chk("R9 overrun", overrun, m_ovr);
            chk("R10 irq", irq, m_irq);
        end
    end

    // prescaler enables and random serial input
    always @(negedge clk) begin
        #1;
        en_cnt++;
        ck_en0 = (en_cnt % 2 == 0);
        ck_en1 = en1_on && (en_cnt % 3 == 0);
        sdi = 1'($urandom);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); #1;
        data_wr = 1; data_wdata = v;
        @(negedge clk); #1;
        data_wr = 0;
    endtask

    task automatic rd();
        @(negedge clk); #1;
        data_rd = 1;
        @(negedge clk); #1;
        data_rd = 0;
    endtask

    task automatic wait_idle();
        int lim = 0;
        while (busy && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        cyc(2);
    endtask

    task automatic frame(input logic sel, input int dv, input logic lsb,
                         input logic l8, input logic pol, input logic isel);
        cfg_clk_sel = sel; cfg_div = DIV_W'(dv); cfg_lsb_first = lsb;
        cfg_len8 = l8; cfg_cpol = pol; cfg_irq_sel = isel;
        cyc(2);
        wr(8'hFF);
        wait_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R7 watchdog: busy=%0d expected 0", busy);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(1);
        // R11: reset state
        chk("R11 busy", busy, 0);
        chk("R11 rx_full", rx_full, 0);
        chk("R11 overrun", overrun, 0);
        chk("R11 irq", irq, 0);
        chk("R11 rd_data", rd_data, 0);
        chk("R4 idle sck cpol=0", sck, 1);

        // R1: write before channel start is ignored
        wr(8'hFF);
        cyc(4);
        chk("R1 no frame before start", busy, 0);

        @(negedge clk); #1 chan_start = 1;
        @(negedge clk); #1 chan_start = 0;

        // R7: non-dummy value is ignored
        wr(8'h55);
        cyc(3);
        chk("R7 non-FF write ignored", busy, 0);

        // R5/R3: MSB first 8-bit, div=1, first enable, complete irq
        cfg_div = 7'd1;
        cyc(2);
        wr(8'hFF);
        cyc(10);
        wr(8'hFF);               // R7: write while busy ignored
        chk("R7 busy during frame", busy, 1);
        wait_idle();
        rd();

        // R4: inverted polarity idle level
        cfg_cpol = 1;
        cyc(2);
        chk("R4 idle sck cpol=1", sck, 0);

        // LSB first 8-bit, div=0, second enable, buffer-empty irq
        frame(1, 0, 1, 1, 1, 1);
        rd();
        // R6: 7-bit MSB first
        frame(0, 2, 0, 0, 0, 0);
        chk("R6 bit7 zero msb", rd_data[7], 0);
        rd();
        // R6: 7-bit LSB first
        frame(1, 1, 1, 0, 1, 0);
        chk("R6 bit7 zero lsb", rd_data[7], 0);
        rd();

        // R9: two frames without read
        frame(0, 0, 0, 1, 0, 0);
        frame(0, 3, 1, 1, 0, 1);
        chk("R9 overrun set", overrun, 1);
        rd();
        cyc(1);
        chk("R8 read clears full", rx_full, 0);
        chk("R8 read clears overrun", overrun, 0);

        // R2: unselected enable has no effect
        cfg_clk_sel = 1; cfg_div = 7'd0; cfg_irq_sel = 0; cfg_cpol = 0;
        en1_on = 0;
        cyc(2);
        wr(8'hFF);
        cyc(20);
        chk("R2 stalled without selected tick", busy, 1);
        chk("R2 sck held idle", sck, 1);
        en1_on = 1;
        wait_idle();
        chk("R2 frame ends after ticks resume", busy, 0);
        rd();
        cyc(3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule